// File: doc/BRIEF.md
# Write-in-Progress Status Responder

This block sits on the device side of a parallel flash-style memory. It takes over the read data bus while an internal program or erase operation is running. The command decoder gives it a one-clock start pulse, a two-bit operation code and, for a program, the word being written. The block then stays busy for a fixed number of clock cycles that depends on the operation. This models the internal write time.

While busy, every read returns a status word instead of array data. Bit 7 is a data-polling bit: it is the complement of bit 7 of the programmed word during a program, and it is 0 during any erase. Bit 6 is a toggle bit: it changes after every read access, not on every clock. All other bits are 0.

When the count runs out, the block issues a one-clock completion pulse. With that pulse it gives the operation code and the word to the array model, which then commits the program or fills the region with FFFFh. After that, reads pass through to the array again. A host therefore sees bit 7 become true data and bit 6 stop changing.

Top module: `wip_status`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o` and `done_o` are 0 and `rd_data_o` equals `arr_data_i`.
- R2: A `start_i` pulse sampled while idle raises `busy_o` from the next cycle for exactly the cycle count chosen by `op_i`: 00 program (`PROG_CYC`), 01 sector erase (`SECT_CYC`), 10 block erase (`BLK_CYC`), 11 chip erase (`CHIP_CYC`).
- R3: `done_o` is high for exactly one cycle, the first cycle after the last busy cycle. In that cycle `done_op_o` and `done_word_o` hold the operation code and word captured at start.
- R4: During a program (op 00), bit 7 of `rd_data_o` reads as the inverse of bit 7 of the captured word.
- R5: During any erase (op 01, 10, 11), bit 7 of `rd_data_o` reads 0.
- R6: During an operation, bit 6 of `rd_data_o` reads 0 up to the first read strobe (`rd_i`). It inverts after each clock in which `rd_i` is high. It holds its value through cycles without `rd_i`.
- R7: While busy, every bit of `rd_data_o` other than bits 7 and 6 reads 0, whatever `arr_data_i` holds.
- R8: While idle, `rd_data_o` equals `arr_data_i`, whether or not `rd_i` is high.
- R9: A `start_i` pulse while busy is ignored: the running operation keeps its length, its status bits and its completion code and word.
- R10: From the completion cycle on, `rd_data_o` again equals `arr_data_i`, so the toggling stops and bit 7 shows true data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse from the command decoder after the final command write |
| op_i | input | 2 | Operation code: 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| wdata_i | input | DW | Word to be programmed, captured on start |
| rd_i | input | 1 | Read strobe, one cycle per host read access |
| arr_data_i | input | DW | Read data from the array model |
| rd_data_o | output | DW | Read data bus: status while busy, array data otherwise |
| busy_o | output | 1 | Internal operation in progress |
| done_o | output | 1 | One-cycle completion pulse to the array model |
| done_op_o | output | 2 | Operation code of the completed operation |
| done_word_o | output | DW | Captured program word for the array model |

## Verification
The bench builds the block with cycle counts of 3, 5, 7 and 9 for program, sector, block and chip erase. These values are short and all different. Every operation can therefore be run to completion, and a wrong length or a swapped operation code shows up as a mismatch in the busy window. The small counts allow a sweep over every operation code, both values of the programmed bit 7, and three read-strobe patterns: every cycle, every other cycle, and none. Every status word is checked cycle by cycle. Runs that inject a second start mid-operation show that it is ignored.

// File: rtl/wip_status.sv
`timescale 1ns/1ps
module wip_status #(
  parameter int DW       = 16,
  parameter int PROG_CYC = 3500,
  parameter int SECT_CYC = 4500000,
  parameter int BLK_CYC  = 4500000,
  parameter int CHIP_CYC = 17500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    done_op_o,
  output logic [DW-1:0] done_word_o
);

  localparam int M1   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int M2   = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [1:0] OP_PROG = 2'b00;

  logic [CW-1:0] cnt, dur;
  logic          busy, done, tgl;
  logic [1:0]    op_q;
  logic [DW-1:0] word_q, stat;

  always_comb begin
    case (op_i)
      2'b00:   dur = CW'(PROG_CYC);
      2'b01:   dur = CW'(SECT_CYC);
      2'b10:   dur = CW'(BLK_CYC);
      default: dur = CW'(CHIP_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      tgl    <= 1'b0;
      cnt    <= '0;
      op_q   <= OP_PROG;
      word_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy   <= 1'b1;
          cnt    <= dur;
          op_q   <= op_i;
          word_q <= wdata_i;
          tgl    <= 1'b0;
        end
      end else begin
        if (rd_i) tgl <= ~tgl;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stat    = '0;
    stat[7] = (op_q == OP_PROG) ? ~word_q[7] : 1'b0;
    stat[6] = tgl;
  end

  assign rd_data_o   = busy ? stat : arr_data_i;
  assign busy_o      = busy;
  assign done_o      = done;
  assign done_op_o   = op_q;
  assign done_word_o = word_q;

endmodule

// File: rtl/wip_status_chk.sv
`timescale 1ns/1ps
module wip_status_chk #(
  parameter int DW       = 16,
  parameter int PROG_CYC = 3500,
  parameter int SECT_CYC = 4500000,
  parameter int BLK_CYC  = 4500000,
  parameter int CHIP_CYC = 17500000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    op_i,
  input logic [DW-1:0] wdata_i,
  input logic          rd_i,
  input logic [DW-1:0] arr_data_i,
  input logic [DW-1:0] rd_data_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    done_op_o,
  input logic [DW-1:0] done_word_o
);
  logic [31:0]   bcnt;
  logic [1:0]    c_op;
  logic [DW-1:0] c_word;
  logic [31:0]   exp_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= 0; c_op <= 2'b00; c_word <= '0;
    end else if (start_i && !busy_o) begin
      bcnt <= 0; c_op <= op_i; c_word <= wdata_i;
    end else if (busy_o) begin
      bcnt <= bcnt + 1;
    end
  end

  always_comb begin
    case (c_op)
      2'b00:   exp_len = PROG_CYC;
      2'b01:   exp_len = SECT_CYC;
      2'b10:   exp_len = BLK_CYC;
      default: exp_len = CHIP_CYC;
    endcase
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bcnt == exp_len));
  p_done_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  p_done_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_info_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (done_op_o == c_op && done_word_o == c_word));
  p_prog_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && c_op == 2'b00) |-> (rd_data_o[7] == ~c_word[7]));
  p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && c_op != 2'b00) |-> (rd_data_o[7] == 1'b0));
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rd_i) |=> (!busy_o || rd_data_o[6] != $past(rd_data_o[6])));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rd_i) |=> (!busy_o || $stable(rd_data_o[6])));
  p_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rd_data_o[5:0] == '0 && rd_data_o[DW-1:8] == '0));
  p_idle_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rd_data_o == arr_data_i));
endmodule

bind wip_status wip_status_chk #(
  .DW(DW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
  .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (.*);

// File: tb/wip_status_test.sv
`timescale 1ns/1ps
module wip_status_test;
  localparam int DW = 16;
  localparam int PC = 3, SC = 5, BC = 7, CC = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [DW-1:0] wdata_i = '0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] arr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          busy_o, done_o;
  logic [1:0]    done_op_o;
  logic [DW-1:0] done_word_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wip_status #(.DW(DW), .PROG_CYC(PC), .SECT_CYC(SC), .BLK_CYC(BC), .CHIP_CYC(CC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .arr_data_i(arr_data_i), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .done_o(done_o), .done_op_o(done_op_o), .done_word_o(done_word_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] op);
    case (op)
      2'b00:   return PC;
      2'b01:   return SC;
      2'b10:   return BC;
      default: return CC;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [DW-1:0] w, input int pat, input bit intrude);
    int n;
    logic exp_t;
    logic [DW-1:0] exp_d;
    string sfx;
    n = len_of(op);
    sfx = intrude ? " R9" : "";
    @(negedge clk);
    start_i = 1'b1; op_i = op; wdata_i = w;
    @(negedge clk);
    start_i = 1'b0; wdata_i = ~w;
    exp_t = 1'b0;
    for (int c = 1; c <= n; c++) begin
      arr_data_i = 16'hA5C3 ^ DW'(c * 16'h1111);
      rd_i = (pat == 0) || (pat == 1 && (c % 2 == 1));
      if (intrude && c == 2) begin
        start_i = 1'b1; op_i = ~op; wdata_i = ~w;
      end
      #1;
      exp_d = '0;
      exp_d[7] = (op == 2'b00) ? ~w[7] : 1'b0;
      exp_d[6] = exp_t;
      chk($sformatf("R2 busy op%0d c%0d%s", op, c, sfx), 32'(busy_o), 32'd1);
      chk($sformatf("R3 no early done op%0d c%0d", op, c), 32'(done_o), 32'd0);
      chk($sformatf("%s R6 R7 status op%0d pat%0d c%0d%s",
                    (op == 2'b00) ? "R4" : "R5", op, pat, c, sfx),
          32'(rd_data_o), 32'(exp_d));
      @(negedge clk);
      if (rd_i) exp_t = ~exp_t;
      start_i = 1'b0;
    end
    rd_i = 1'b1;
    arr_data_i = 16'h0F0F ^ w;
    #1;
    chk($sformatf("R2 busy ends op%0d%s", op, sfx), 32'(busy_o), 32'd0);
    chk($sformatf("R3 done op%0d", op), 32'(done_o), 32'd1);
    chk($sformatf("R3 done_op op%0d%s", op, sfx), 32'(done_op_o), 32'(op));
    chk($sformatf("R3 done_word op%0d%s", op, sfx), 32'(done_word_o), 32'(w));
    chk($sformatf("R10 passthrough op%0d", op), 32'(rd_data_o), 32'(16'h0F0F ^ w));
    @(negedge clk);
    rd_i = 1'b0;
    #1;
    chk($sformatf("R3 done single op%0d", op), 32'(done_o), 32'd0);
    chk($sformatf("R10 stable after op%0d", op), 32'(rd_data_o), 32'(16'h0F0F ^ w));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    arr_data_i = 16'h3C5A;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    chk("R1 done in reset", 32'(done_o), 32'd0);
    chk("R1 data in reset", 32'(rd_data_o), 32'h3C5A);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    chk("R1 done after reset", 32'(done_o), 32'd0);

    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      arr_data_i = DW'(16'h1 << (2 * k)) ^ 16'hFFC0;
      rd_i = k[0];
      #1;
      chk($sformatf("R8 idle pass k%0d", k), 32'(rd_data_o), 32'(arr_data_i));
      chk($sformatf("R8 idle no busy k%0d", k), 32'(busy_o), 32'd0);
    end
    rd_i = 1'b0;

    for (int op = 0; op < 4; op++)
      for (int b = 0; b < 2; b++)
        for (int pat = 0; pat < 3; pat++)
          run_op(2'(op), b ? 16'h12B4 : 16'hED4B, pat, 1'b0);

    for (int op = 0; op < 4; op++)
      run_op(2'(op), 16'h0080 ^ DW'(op), 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule